// File: doc/BRIEF.md
# Flash Erase Command Interpreter

This block is the erase-command front end of a NAND-style flash device. It watches an 8-bit bus and takes one byte on each low-to-high transition of the write strobe. A command strobe or an address strobe, sampled with that byte, marks it as a command or as an address. A block erase is armed by a setup command, then takes a fixed number of address bytes, and starts on a confirm command. While the erase runs, the ready output is held low. A cycle counter of configurable length stands in for the array erase time.

A running erase can be suspended and later resumed. The remaining time is kept across the suspend, so a resume only runs the time that was left. While an erase is suspended, a fresh erase cannot be set up. A reset command aborts everything. A status byte reports ready, suspended and the pass/fail result of the last erase. A fail-injection input lets a test force the failure result. The block being erased is presented on its own output.

Top module: `fe_ctrl`

## Requirements
- R1: The sequence command 60h, two address bytes, command D0h starts an erase on the clock edge that takes the D0h byte. From that edge `rdy_o` is 0 and `blk_vld_o` is 1.
- R2: The block number is {second address byte bits 5:0, first address byte bits 7:4}. First-byte bits 3:0 and second-byte bits 7:6 have no effect. `blk_o` holds this value for as long as `blk_vld_o` is 1.
- R3: A malformed sequence starts no erase and returns to idle. Malformed means D0h after fewer than two address bytes, or a third address byte. Address bytes outside a setup are ignored.
- R4: An erase that is not interrupted keeps `rdy_o` low for exactly ERASE_CYCLES clock cycles. After that, `rdy_o` and `status_o[6]` are 1 and `blk_vld_o` is 0.
- R5: While an erase runs, every command except B0h and FFh is ignored, together with all address bytes. The block number and the remaining time are unchanged.
- R6: B0h during a running erase suspends it. `rdy_o` goes to 1, `status_o[5]` goes to 1 and the remaining time is frozen. B0h at any other time has no effect.
- R7: D0h while suspended resumes the same block. `rdy_o` is then low for exactly the time that remained at the suspend.
- R8: While suspended, a 60h setup and its address bytes are rejected. The suspended block and its remaining time are kept.
- R9: After reset, `status_o` is 40h, `rdy_o` is 1 and `blk_vld_o` is 0. Command FFh in any state aborts a running or suspended erase, clears `status_o[5]` and `status_o[0]`, and returns to idle. A new erase is then accepted.
- R10: When an erase completes, `status_o[0]` takes the value of `fail_inj_i` in the completing cycle (0 pass, 1 fail). It holds that value until the next completion or an FFh command.
- R11: A B0h taken in the final cycle of an erase wins over completion. The erase is suspended with one cycle left, and a resume then holds `rdy_o` low for exactly one cycle.
- R12: A byte is taken only on a 0-to-1 transition of `we_i`, so holding `we_i` high takes the byte once. A write with neither `cle_i` nor `ale_i` high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe; a byte is taken on its rising transition |
| cle_i | input | 1 | The byte is a command |
| ale_i | input | 1 | The byte is an address (only when `cle_i` is low) |
| io_i | input | 8 | Bus byte |
| fail_inj_i | input | 1 | Forces a failed result on erase completion |
| rdy_o | output | 1 | 1 = ready, 0 = erase running |
| status_o | output | 8 | Bit 6 ready, bit 5 suspended, bit 0 last erase failed; other bits 0 |
| blk_vld_o | output | 1 | An erase is running or suspended |
| blk_o | output | BLK_W | Block being erased |

## Verification
Completion and suspend can fall in the same cycle. The bench provokes this by counting cycles from the confirm edge and timing the B0h write so that it is taken on the very edge where the counter expires. The outcome is judged at the ports: the status must show the erase suspended, and a resume must keep `rdy_o` low for exactly one cycle. A behavioural model compares ready, status and block number on every cycle, so collisions such as a 60h setup arriving during a suspend are also caught.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY, ST_SUSP} fe_state_e;
  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
endpackage

// File: rtl/fe_bus_capture.sv
module fe_bus_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          cle_i,
  input  logic          ale_i,
  input  logic [DW-1:0] io_i,
  output logic          cmd_stb_o,
  output logic          adr_stb_o,
  output logic [DW-1:0] byte_o
);
  logic we_q;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b0;
    else         we_q <= we_i;
  end

  assign rise      = we_i & ~we_q;
  assign cmd_stb_o = rise & cle_i;
  assign adr_stb_o = rise & ale_i & ~cle_i;  // command strobe wins
  assign byte_o    = io_i;
endmodule

// File: rtl/fe_blk_addr.sv
module fe_blk_addr #(
  parameter int unsigned ADDR_CYC = 2,
  parameter int unsigned BLK_W    = 10,
  parameter int unsigned BLK_LSB  = 4,
  localparam int unsigned IDX_W   = $clog2(ADDR_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [BLK_W-1:0] blk_o
);
  logic [BLK_W-1:0] blk_q;
  logic             unused_byte_bits;

  assign unused_byte_bits = ^byte_i;

  // each block bit picks its source byte and bit from its position in the address stream
  for (genvar b = 0; b < BLK_W; b++) begin : g_bit
    localparam int unsigned POS = BLK_LSB + b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) blk_q[b] <= 1'b0;
      else if (we_i && idx_i == IDX_W'(POS / 8)) blk_q[b] <= byte_i[POS % 8];
    end
  end

  assign blk_o = blk_q;
endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer #(
  parameter int unsigned CYCLES = 40,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  logic run_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= CNT_W'(CYCLES);
    else if (run_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 40,
  parameter int unsigned ADDR_CYC     = 2,
  parameter int unsigned BLK_W        = 10,
  parameter int unsigned BLK_LSB      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [7:0]       io_i,
  input  logic             fail_inj_i,
  output logic             rdy_o,
  output logic [7:0]       status_o,
  output logic             blk_vld_o,
  output logic [BLK_W-1:0] blk_o
);
  localparam int unsigned IDX_W = $clog2(ADDR_CYC + 1);

  logic             cmd_stb, adr_stb;
  logic [7:0]       bus_byte;
  fe_state_e        state_q, state_d;
  logic [IDX_W-1:0] adr_n_q, adr_n_d;
  logic             adr_we, tmr_ld, tmr_run, tmr_clr, tmr_last;
  logic             done, rst_cmd, fail_q;

  fe_bus_capture #(.DW(8)) i_bus (
    .clk_i, .rst_ni, .we_i, .cle_i, .ale_i, .io_i,
    .cmd_stb_o(cmd_stb), .adr_stb_o(adr_stb), .byte_o(bus_byte)
  );

  fe_blk_addr #(.ADDR_CYC(ADDR_CYC), .BLK_W(BLK_W), .BLK_LSB(BLK_LSB)) i_addr (
    .clk_i, .rst_ni, .we_i(adr_we), .idx_i(adr_n_q), .byte_i(bus_byte), .blk_o
  );

  fe_erase_timer #(.CYCLES(ERASE_CYCLES)) i_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .load_i(tmr_ld), .run_i(tmr_run), .last_o(tmr_last)
  );

  always_comb begin
    state_d = state_q;
    adr_n_d = adr_n_q;
    adr_we  = 1'b0;
    tmr_ld  = 1'b0;
    tmr_run = 1'b0;
    tmr_clr = 1'b0;
    done    = 1'b0;
    rst_cmd = cmd_stb && bus_byte == CMD_RESET;
    if (rst_cmd) begin
      state_d = ST_IDLE;
      tmr_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_SETUP: begin
          if (cmd_stb) begin
            if (bus_byte == CMD_SETUP) begin
              state_d = ST_SETUP;
              adr_n_d = '0;
            end else if (bus_byte == CMD_CONFIRM && state_q == ST_SETUP &&
                         adr_n_q == IDX_W'(ADDR_CYC)) begin
              state_d = ST_BUSY;
              tmr_ld  = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (adr_stb && state_q == ST_SETUP) begin
            if (adr_n_q < IDX_W'(ADDR_CYC)) begin
              adr_we  = 1'b1;
              adr_n_d = adr_n_q + IDX_W'(1);
            end else begin
              state_d = ST_IDLE;  // too many address bytes
            end
          end
        end
        ST_BUSY: begin
          // suspend beats completion in the same cycle
          if (cmd_stb && bus_byte == CMD_SUSPEND) begin
            state_d = ST_SUSP;
          end else begin
            tmr_run = 1'b1;
            if (tmr_last) begin
              state_d = ST_IDLE;
              done    = 1'b1;
            end
          end
        end
        ST_SUSP: if (cmd_stb && bus_byte == CMD_CONFIRM) state_d = ST_BUSY;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      adr_n_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      adr_n_q <= adr_n_d;
      if (rst_cmd)   fail_q <= 1'b0;
      else if (done) fail_q <= fail_inj_i;
    end
  end

  assign rdy_o     = (state_q != ST_BUSY);
  assign blk_vld_o = (state_q == ST_BUSY) || (state_q == ST_SUSP);
  assign status_o  = {1'b0, rdy_o, state_q == ST_SUSP, 4'b0000, fail_q};
endmodule

// File: rtl/fe_ctrl_chk.sv
module fe_ctrl_chk #(
  parameter int unsigned BLK_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             cle_i,
  input logic [7:0]       io_i,
  input logic             rdy_o,
  input logic [7:0]       status_o,
  input logic             blk_vld_o,
  input logic [BLK_W-1:0] blk_o
);
  p_start_on_confirm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(we_i && cle_i && (io_i == 8'hD0)));

  p_start_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_vld_o) |-> !rdy_o);

  p_blk_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_o && $past(blk_vld_o)) |-> $stable(blk_o));

  p_susp_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] |-> (rdy_o && blk_vld_o));

  p_no_setup_in_susp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && we_i && cle_i && io_i == 8'h60) |=> blk_vld_o);

  p_fail_on_finish_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> (rdy_o && !blk_vld_o && $past(!rdy_o)));
endmodule

bind fe_ctrl fe_ctrl_chk #(.BLK_W(BLK_W)) i_fe_ctrl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .cle_i(cle_i), .io_i(io_i),
  .rdy_o(rdy_o), .status_o(status_o), .blk_vld_o(blk_vld_o), .blk_o(blk_o)
);

// File: tb/test_fe_ctrl.sv
module test_fe_ctrl;
  localparam int N = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0, cle_i = 1'b0, ale_i = 1'b0, fail_inj_i = 1'b0;
  logic [7:0] io_i = 8'h00;
  logic       rdy_o, blk_vld_o;
  logic [7:0] status_o;
  logic [9:0] blk_o;

  int    total = 0, bad = 0;
  bit    finished = 1'b0;
  string cur = "R9";

  always #2.5 clk_i = ~clk_i;

  fe_ctrl #(.ERASE_CYCLES(N)) i_fe_ctrl (
    .clk_i, .rst_ni, .we_i, .cle_i, .ale_i, .io_i, .fail_inj_i,
    .rdy_o, .status_o, .blk_vld_o, .blk_o
  );

  // behavioural reference model
  bit         m_we_q, m_busy, m_susp, m_fail, m_setup;
  int         m_n, m_left;
  logic [7:0] m_a0, m_a1;

  always @(posedge clk_i) begin
    bit sc, sa;
    if (!rst_ni) begin
      m_we_q <= 0; m_busy <= 0; m_susp <= 0; m_fail <= 0; m_setup <= 0;
      m_n <= 0; m_left <= 0; m_a0 <= 0; m_a1 <= 0;
    end else begin
      sc = we_i && !m_we_q && cle_i;
      sa = we_i && !m_we_q && ale_i && !cle_i;
      m_we_q <= we_i;
      if (sc && io_i == 8'hFF) begin
        m_busy <= 0; m_susp <= 0; m_setup <= 0; m_fail <= 0;
      end else if (m_busy) begin
        if (sc && io_i == 8'hB0) begin m_busy <= 0; m_susp <= 1; end
        else if (m_left == 1) begin m_busy <= 0; m_fail <= fail_inj_i; end
        else m_left <= m_left - 1;
      end else if (m_susp) begin
        if (sc && io_i == 8'hD0) begin m_susp <= 0; m_busy <= 1; end
      end else if (sc) begin
        if (io_i == 8'h60) begin m_setup <= 1; m_n <= 0; end
        else if (io_i == 8'hD0 && m_setup && m_n == 2) begin
          m_busy <= 1; m_left <= N; m_setup <= 0;
        end else m_setup <= 0;
      end else if (sa && m_setup) begin
        if (m_n == 0) begin m_a0 <= io_i; m_n <= 1; end
        else if (m_n == 1) begin m_a1 <= io_i; m_n <= 2; end
        else m_setup <= 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk({cur, " model rdy"}, rdy_o, !m_busy);
      chk({cur, " model status"}, status_o, {1'b0, !m_busy, m_susp, 4'b0, m_fail});
      chk({cur, " model vld"}, blk_vld_o, m_busy || m_susp);
      if (m_busy || m_susp) chk({cur, " model blk"}, blk_o, {m_a1[5:0], m_a0[7:4]});
    end
  end

  task automatic wr(input bit c, input bit a, input logic [7:0] b);
    @(negedge clk_i);
    cle_i = c; ale_i = a; io_i = b; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; cle_i = 1'b0; ale_i = 1'b0;
  endtask

  task automatic erase(input logic [7:0] a0, input logic [7:0] a1);
    wr(1, 0, 8'h60); wr(0, 1, a0); wr(0, 1, a1); wr(1, 0, 8'hD0);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!rdy_o && n < 4 * N) begin n++; @(negedge clk_i); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9: reset state
    chk("R9 reset rdy", rdy_o, 1); chk("R9 reset status", status_o, 8'h40);
    chk("R9 reset vld", blk_vld_o, 0);

    cur = "R1";
    erase(8'hA5, 8'hC3);
    chk("R1 busy after confirm", rdy_o, 0); chk("R1 vld", blk_vld_o, 1);
    chk("R2 block number", blk_o, 10'h03A);
    busy_len(n); chk("R4 busy length", n, N);
    chk("R4 ready status", status_o[6], 1); chk("R10 pass bit", status_o[0], 0);

    cur = "R2";
    erase(8'hAF, 8'h43);
    chk("R2 ignored bits", blk_o, 10'h03A);
    busy_len(n);

    cur = "R3";
    wr(1, 0, 8'h60); wr(0, 1, 8'h11); wr(1, 0, 8'hD0); @(negedge clk_i);
    chk("R3 short seq rdy", rdy_o, 1); chk("R3 short seq vld", blk_vld_o, 0);
    wr(1, 0, 8'h60); wr(0, 1, 8'h11); wr(0, 1, 8'h22); wr(0, 1, 8'h33); wr(1, 0, 8'hD0);
    @(negedge clk_i);
    chk("R3 long seq vld", blk_vld_o, 0);
    wr(0, 1, 8'h44); wr(1, 0, 8'hD0); @(negedge clk_i);
    chk("R3 stray addr vld", blk_vld_o, 0);

    cur = "R5";
    erase(8'h20, 8'h01);
    wr(1, 0, 8'h60); wr(0, 1, 8'hF0); wr(0, 1, 8'h3F); wr(1, 0, 8'hD0);
    chk("R5 blk kept", blk_o, 10'h012);
    busy_len(n); chk("R5 time kept", n, N - 8);

    cur = "R6";
    wr(1, 0, 8'hB0); @(negedge clk_i);
    chk("R6 idle suspend ignored", status_o, 8'h40);
    erase(8'h70, 8'h02);
    repeat (5) @(negedge clk_i);
    wr(1, 0, 8'hB0);
    chk("R6 suspended status", status_o, 8'h60); chk("R6 rdy", rdy_o, 1);
    cur = "R8";
    wr(1, 0, 8'h60); wr(0, 1, 8'h00); wr(0, 1, 8'h00);
    chk("R8 still suspended", status_o[5], 1); chk("R8 blk kept", blk_o, 10'h027);
    cur = "R7";
    wr(1, 0, 8'hD0);
    chk("R7 resumed blk", blk_o, 10'h027);
    busy_len(n); chk("R7 remaining time", n, N - 6);

    cur = "R10";
    fail_inj_i = 1'b1;
    erase(8'h10, 8'h00);
    busy_len(n);
    fail_inj_i = 1'b0;
    chk("R10 fail bit", status_o[0], 1);
    repeat (3) @(negedge clk_i);
    chk("R10 fail held", status_o[0], 1);

    cur = "R9";
    wr(1, 0, 8'hFF);
    chk("R9 reset clears fail", status_o, 8'h40);
    erase(8'h30, 8'h00);
    repeat (3) @(negedge clk_i);
    wr(1, 0, 8'hFF);
    chk("R9 abort busy rdy", rdy_o, 1); chk("R9 abort busy vld", blk_vld_o, 0);
    erase(8'h30, 8'h00); wr(1, 0, 8'hB0); wr(1, 0, 8'hFF);
    chk("R9 abort suspend", status_o, 8'h40); chk("R9 abort suspend vld", blk_vld_o, 0);
    erase(8'h40, 8'h00);
    busy_len(n); chk("R9 new erase after abort", n, N);

    cur = "R11";
    erase(8'h50, 8'h00);
    repeat (N - 2) @(negedge clk_i);
    wr(1, 0, 8'hB0);
    chk("R11 suspend wins", status_o, 8'h60);
    wr(1, 0, 8'hD0);
    busy_len(n); chk("R11 one cycle left", n, 1);

    cur = "R12";
    @(negedge clk_i);
    cle_i = 1'b1; io_i = 8'h60; we_i = 1'b1;
    @(negedge clk_i); io_i = 8'hB0;
    @(negedge clk_i); io_i = 8'hD0;
    @(negedge clk_i); we_i = 1'b0; cle_i = 1'b0;
    chk("R12 held strobe no start", blk_vld_o, 0);
    wr(0, 1, 8'h90); wr(0, 1, 8'h05); wr(0, 0, 8'hFF); wr(1, 0, 8'hD0);
    chk("R12 setup kept", rdy_o, 0); chk("R12 blk", blk_o, 10'h059);
    busy_len(n); chk("R12 busy length", n, N);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule